// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer that sits beside a processor's local interrupt controller. Software programs a start value, a clock divider and a control entry holding a mask flag and a mode flag. The timer then counts down once per divided tick and reports each expiry to the interrupt logic as a pulse one cycle wide. In one-shot mode it stops at zero after a single expiry. In periodic mode it reloads the start value and keeps running. Loading a new start value always restarts the countdown from that value, and the divider restarts with it.

The count runs in a small state machine with three states. `ST_IDLE` is the state after reset, before any load. `ST_ARMED` means the timer is counting. `ST_SPENT` means a one-shot run has finished and the count is held at zero. The transitions are:
- load: any state goes to `ST_ARMED`, or to `ST_SPENT` when a one-shot zero value is loaded.
- drain: `ST_ARMED` stays in `ST_ARMED` while a tick takes the count down by one.
- wrap: `ST_ARMED` stays in `ST_ARMED` when a periodic tick at zero reloads the start value.
- finish: `ST_ARMED` goes to `ST_SPENT` when a one-shot tick arrives at zero.

Only a load leaves `ST_SPENT`. The live count is always visible on an output port. Vector delivery, priority handling and deadline operation are handled elsewhere.

Top module: `lt_timer`

## Requirements
- R1: After reset the live count is 0 and no expiry is signalled. The divide code is 0, which gives divide-by-2, and the mask flag is set, so a load made before any other write counts down but never signals an expiry.
- R2: The divide code is built from `wr_data` bits 3, 1 and 0, taken together as a 3-bit value v = {b3,b1,b0}. Codes 0 to 6 give a tick every 2^(v+1) clock cycles, and code 7 gives a tick on every cycle.
- R3: A write to address 0 loads `wr_data` as the start value. The live count shows that value in the cycle after the write edge, and the divider restarts, so the first decrement comes a full 2^shift cycles after the load edge.
- R4: In one-shot mode the count drops by one on each tick, never rises except on a load, and holds at 0 once it gets there.
- R5: In one-shot mode with a start value N > 0, exactly one expiry pulse, one cycle wide, follows the edge that is (N+1) ticks after the load. No further pulse comes until the next load.
- R6: In periodic mode with start value N > 0, the count runs N down to 0 and then reloads N. An expiry pulse follows every (N+1) ticks, and the count never exceeds N.
- R7: A start value of 0 never produces an expiry, in either mode.
- R8: While the mask flag is set, no expiry pulse is produced, but counting and reloading go on unchanged.
- R9: Address 2 holds the control entry. `wr_data` bit 16 is the mask flag and bit 17 selects periodic (1) or one-shot (0). Address 1 holds the divide code.
- R10: Writes to the divide or control addresses do not reload or restart the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 start value, 1 divide code, 2 control entry |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Live countdown value |
| expire | output | 1 | One-cycle expiry pulse |

## Verification
The hardest point to pin down from the ports is the exact edge on which an expiry fires. That edge depends on how the divider phase lines up with the load, and a one-cycle error would still look plausible. The stimulus therefore reloads the start value for every case, which puts the divider at a known phase. It then counts pulses and samples the live count after an exact number of cycles, with windows chosen to end one cycle before and one cycle after the expected expiry. Further directed loads land in the middle of a run, together with mid-run divide and control writes, to show that only a load restarts the divider.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SPENT = 2'd2
    } lt_state_e;

    localparam logic [1:0] ADDR_START = 2'd0;
    localparam logic [1:0] ADDR_DIV   = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    localparam int CTRL_MASK_BIT = 16;
    localparam int CTRL_PER_BIT  = 17;
    localparam int SHIFT_W       = 3;

    // Three significant divide bits; all-ones selects divide by one.
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [2:0] code);
        return (code == 3'b111) ? '0 : SHIFT_W'(code + 3'd1);
    endfunction

endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PW = (1 << SHIFT_W) - 1;

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] lim;

    always_comb begin
        lim  = ~({PW{1'b1}} << shift);
        tick = (cnt_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: a restart under a real divider delays the next tick
    assert_first_tick_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && shift != '0) |=> (shift == '0 || !tick));

endmodule

// File: rtl/lt_count_fsm.sv
module lt_count_fsm
    import lt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic             masked,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    lt_state_e        state_q, state_d;
    logic [CNT_W-1:0] cur_q, cur_d;
    logic [CNT_W-1:0] reload_q;
    logic             fire;

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        fire    = 1'b0;
        if (load) begin
            cur_d   = load_val;
            state_d = (load_val == '0 && !periodic) ? ST_SPENT : ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: begin
                    if (tick) begin
                        if (cur_q != '0) begin
                            cur_d = cur_q - 1'b1;
                        end else if (periodic) begin
                            cur_d = reload_q;
                            fire  = (reload_q != '0);
                        end else begin
                            state_d = ST_SPENT;
                            fire    = (reload_q != '0);
                        end
                    end
                end
                ST_SPENT: state_d = ST_SPENT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            reload_q <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            if (load) reload_q <= load_val;
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) expire <= 1'b0;
        else        expire <= fire && !masked;
    end

    assign count = cur_q;

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> !$past(masked));

    assert_spent_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT) |-> (cur_q == '0));

    assert_oneshot_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !periodic) |=> (cur_q <= $past(cur_q)));

    assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= reload_q);

    assert_zero_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_q == '0 && !load) |=> !expire);

endmodule

// File: rtl/lt_timer.sv
module lt_timer
    import lt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cur_count,
    output logic              expire
);
    logic [2:0]         div_sel_q;
    logic               ctrl_mask_q;
    logic               ctrl_per_q;
    logic               load;
    logic               tick;
    logic [SHIFT_W-1:0] shift;

    assign load  = wr_en && (wr_addr == ADDR_START);
    assign shift = div_to_shift(div_sel_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_sel_q   <= 3'd0;
            ctrl_mask_q <= 1'b1;
            ctrl_per_q  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_DIV) div_sel_q <= {wr_data[3], wr_data[1:0]};
            if (wr_addr == ADDR_CTRL) begin
                ctrl_mask_q <= wr_data[CTRL_MASK_BIT];
                ctrl_per_q  <= wr_data[CTRL_PER_BIT];
            end
        end
    end

    lt_prescaler #(.SHIFT_W(SHIFT_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .shift   (shift),
        .tick    (tick)
    );

    lt_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wr_data[CNT_W-1:0]),
        .tick     (tick),
        .periodic (ctrl_per_q),
        .masked   (ctrl_mask_q),
        .count    (cur_count),
        .expire   (expire)
    );

    assert_load_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_count == $past(wr_data[CNT_W-1:0])));

endmodule

// File: tb/test_lt_timer.sv
module test_lt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] cur_count;
    logic        expire;

    int n_checks = 0;
    int n_fail   = 0;
    int n_pulse;

    always #10 clk = ~clk;

    lt_timer i_lt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cur_count (cur_count),
        .expire    (expire)
    );

    typedef struct packed {
        logic        per;
        logic        msk;
        logic [3:0]  dcode;
        logic [31:0] start;
        logic [15:0] ncyc;
        logic [7:0]  pulses;
        logic [31:0] endcnt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 4'hB, 32'd5,  16'd20,  8'd1, 32'd0},  // R5
        '{1'b0, 1'b0, 4'h0, 32'd3,  16'd7,   8'd0, 32'd0},  // R4 one cycle early
        '{1'b0, 1'b0, 4'h0, 32'd3,  16'd8,   8'd1, 32'd0},  // R5 exact edge
        '{1'b1, 1'b0, 4'hB, 32'd4,  16'd23,  8'd4, 32'd1},  // R6
        '{1'b1, 1'b0, 4'h1, 32'd2,  16'd30,  8'd2, 32'd1},  // R6 R2
        '{1'b1, 1'b1, 4'hB, 32'd3,  16'd17,  8'd0, 32'd2},  // R8 periodic masked
        '{1'b0, 1'b1, 4'hB, 32'd2,  16'd10,  8'd0, 32'd0},  // R8 one-shot masked
        '{1'b1, 1'b0, 4'hB, 32'd0,  16'd10,  8'd0, 32'd0},  // R7 periodic zero
        '{1'b0, 1'b0, 4'hB, 32'd0,  16'd10,  8'd0, 32'd0},  // R7 one-shot zero
        '{1'b1, 1'b0, 4'h2, 32'd1,  16'd40,  8'd2, 32'd0},  // R2 divide 8
        '{1'b0, 1'b0, 4'hA, 32'd1,  16'd300, 8'd1, 32'd0},  // R2 divide 128
        '{1'b0, 1'b0, 4'h3, 32'd10, 16'd100, 8'd0, 32'd4},  // R2 divide 16
        '{1'b1, 1'b0, 4'h8, 32'd2,  16'd200, 8'd2, 32'd2}   // R2 divide 32, R9
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; the write takes effect on the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        n_pulse = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (expire) n_pulse++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "count after reset", cur_count, 32'd0);
        check("R1", "expiry after reset", {31'd0, expire}, 32'd0);

        // R1: default divide-by-2 and masked control
        wr(2'd0, 32'd3);
        check("R3", "load visible", cur_count, 32'd3);
        run(2);
        check("R1", "default divide first tick", cur_count, 32'd2);
        run(20);
        check("R1", "default mask suppresses expiry", n_pulse, 32'd0);
        check("R1", "count drained", cur_count, 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, {28'd0, TBL[i].dcode});
            wr(2'd2, (32'(TBL[i].per) << 17) | (32'(TBL[i].msk) << 16));
            wr(2'd0, TBL[i].start);
            run(int'(TBL[i].ncyc));
            check("R9 table", $sformatf("entry %0d pulses", i), n_pulse, 32'(TBL[i].pulses));
            check("R9 table", $sformatf("entry %0d count", i), cur_count, TBL[i].endcnt);
        end

        // R3: reload mid-run restarts from the start value
        wr(2'd1, 32'hB);
        wr(2'd2, 32'h0002_0000);
        wr(2'd0, 32'd9);
        run(4);
        check("R3", "mid-run count", cur_count, 32'd5);
        wr(2'd0, 32'd9);
        check("R3", "reload restores start", cur_count, 32'd9);

        // R3: divider restarts on load
        wr(2'd1, 32'h1);
        wr(2'd0, 32'd5);
        run(3);
        check("R3", "no tick before full divide period", cur_count, 32'd5);
        run(1);
        check("R3", "first tick after full period", cur_count, 32'd4);

        // R10: control and divide writes do not restart
        wr(2'd1, 32'hB);
        wr(2'd0, 32'd20);
        run(5);
        check("R10", "before control write", cur_count, 32'd15);
        wr(2'd2, 32'h0002_0000);
        check("R10", "after control write", cur_count, 32'd14);
        wr(2'd1, 32'h0);
        check("R10", "after divide write", cur_count, 32'd13);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule